// File: doc/BRIEF.md
# Audio FIFO Error and Interrupt Status

This block sits between a host register port and the two converter-side sample streams of an audio codec data path. It holds a playback byte FIFO, which the host fills and a converter strobe drains, and a capture byte FIFO, which a converter strobe fills and the host drains. It watches both FIFOs for overrun and underrun and records each fault in a sticky flag. It also latches interrupt-pending flags from three external terminal-count pulses: playback count, capture count and timer.

The host reads the seven flags as one status byte. It clears interrupt flags one at a time by writing zeros to an alternate status location. A strobe on the main status register clears every flag together. A single-DMA-channel mode input sends both count pulses to the playback interrupt flag. The `irq` output is raised while any interrupt flag is pending.

Top module: `audio_fifo_status`

## Requirements
- R1: After reset, `status_q` is 0x00, `irq` is 0, and both FIFOs are empty.
- R2: The playback FIFO holds up to 16 bytes. Each `pb_req` strobe on a non-empty FIFO returns the oldest byte on `pb_sample`, with `pb_sample_vld` high one cycle later. The capture FIFO does the same for `cap_rd` through `cap_rd_data` and `cap_rd_vld`.
- R3: A `pb_req` on an empty playback FIFO sets status bit 0 (playback underrun). `pb_sample_vld` stays low and `pb_sample` keeps its previous value.
- R4: A `pb_wr` to a full playback FIFO sets status bit 1 (playback overrun). The byte is discarded and the FIFO contents are unchanged.
- R5: A `cap_strobe` while the capture FIFO is full sets status bit 2 (capture overrun). The new sample is dropped and the stored samples are kept.
- R6: A `cap_rd` on an empty capture FIFO sets status bit 3 (capture underrun). `cap_rd_data` keeps presenting the last valid byte, and the FIFO pointers do not move.
- R7: `cnt_pb_tc`, `cnt_cap_tc` and `tmr_tc` set status bits 4, 5 and 6 on the next clock. `irq` is the OR of bits 6..4.
- R8: On `alt_wr`, every interrupt bit (6..4) whose `alt_wdata` bit is 0 is cleared. A 1 leaves that bit unchanged. Error bits 3..0 are not affected by `alt_wr`.
- R9: `main_wr` clears all seven status flags, whatever the write data.
- R10: A set event in the same cycle as a clear (`alt_wr` or `main_wr`) leaves the flag set.
- R11: While `single_dma` is 1, both `cnt_pb_tc` and `cnt_cap_tc` set bit 4, and bit 5 never sets.
- R12: Status bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pb_wr | input | 1 | Host write strobe into the playback FIFO |
| pb_wr_data | input | 8 | Host playback byte |
| pb_req | input | 1 | Converter request for the next playback byte |
| pb_sample | output | 8 | Last byte delivered to the playback converter |
| pb_sample_vld | output | 1 | One-cycle pulse: `pb_sample` was just refreshed |
| cap_strobe | input | 1 | Converter strobe pushing a capture byte |
| cap_data | input | 8 | Capture byte from the converter |
| cap_rd | input | 1 | Host read strobe from the capture FIFO |
| cap_rd_data | output | 8 | Last byte read by the host |
| cap_rd_vld | output | 1 | One-cycle pulse: `cap_rd_data` was just refreshed |
| cnt_pb_tc | input | 1 | Playback count terminal pulse |
| cnt_cap_tc | input | 1 | Capture count terminal pulse |
| tmr_tc | input | 1 | Timer terminal pulse |
| single_dma | input | 1 | Single-DMA-channel routing mode |
| alt_wr | input | 1 | Write strobe to the alternate status location |
| alt_wdata | input | 8 | Data for the alternate status write |
| main_wr | input | 1 | Write strobe to the main status register (clear all) |
| status_q | output | 8 | Status byte {0, TI, CI, PI, CU, CO, PO, PU} |
| irq | output | 1 | Any interrupt flag pending |

## Verification
A wrong FIFO pointer or count shows up at the data ports. A sample arrives out of order, a duplicate or an extra `*_vld` pulse appears, or the underrun/overrun flag is raised one byte too early or too late. The scoreboard sees this on the cycle right after the strobe that misbehaves. A wrong flag latch shows up in `status_q` and `irq` one clock after the set or clear event. The bench reads the byte at that point after each set pulse, each partial clear, each mode change and each simultaneous set/clear.

// File: rtl/afs_pkg.sv
package afs_pkg;

    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 16;
    localparam int STAT_W     = 8;
    localparam int N_ERR      = 4;

    // Status byte bit positions (the host decodes these)
    localparam int BIT_PU = 0;
    localparam int BIT_PO = 1;
    localparam int BIT_CO = 2;
    localparam int BIT_CU = 3;
    localparam int BIT_PI = 4;
    localparam int BIT_CI = 5;
    localparam int BIT_TI = 6;

    typedef struct packed {
        logic ti;
        logic ci;
        logic pi;
    } irq_flags_t;

    typedef struct packed {
        logic cu;
        logic co;
        logic po;
        logic pu;
    } err_flags_t;

    function automatic logic [STAT_W-1:0] pack_status(irq_flags_t irqf, err_flags_t errf);
        return {1'b0, irqf, errf};
    endfunction

endpackage

// File: rtl/afs_byte_fifo.sv
module afs_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_vld,
    output logic             full,
    output logic             empty,
    output logic             push_drop,
    output logic             pop_miss
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    cnt;
    logic             do_push;
    logic             do_pop;

    assign full      = (cnt == FULL_CNT);
    assign empty     = (cnt == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign push_drop = push && full;
    assign pop_miss  = pop && empty;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
        end else if (do_push) begin
            wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr <= '0;
        end else if (do_pop) begin
            rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_vld <= do_pop;
            if (do_pop) begin
                rd_data <= mem[rptr];
            end
        end
    end

    // R4 / R5: a refused push leaves the FIFO full
    a_r4_full_kept: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> full);

    // R3 / R6: a refused pop keeps the FIFO empty and the output byte steady
    a_r6_empty_hold: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (empty && $stable(rd_data) && !rd_vld));

    // R2: the occupancy never exceeds the depth
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

endmodule

// File: rtl/afs_err_latch.sv
module afs_err_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr_all,
    output logic [N-1:0] flags
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[g] <= 1'b0;
            end else if (evt[g]) begin
                flags[g] <= 1'b1;
            end else if (clr_all) begin
                flags[g] <= 1'b0;
            end
        end

        // R3..R6, R10: a fault event always leaves its flag set
        a_r10_err_set_wins: assert property (@(posedge clk) disable iff (rst)
            evt[g] |=> flags[g]);

        // R9: a clear with no event drops the flag
        a_r9_err_clear: assert property (@(posedge clk) disable iff (rst)
            (clr_all && !evt[g]) |=> !flags[g]);
    end

endmodule

// File: rtl/afs_irq_latch.sv
module afs_irq_latch
    import afs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pb_tc,
    input  logic              cap_tc,
    input  logic              tmr_tc,
    input  logic              single_dma,
    input  logic              alt_wr,
    input  logic [STAT_W-1:0] alt_wdata,
    input  logic              clr_all,
    output irq_flags_t        flags
);

    irq_flags_t set_vec;
    irq_flags_t clr_vec;
    logic       unused_wdata;

    assign unused_wdata = ^{alt_wdata[STAT_W-1], alt_wdata[BIT_CU:BIT_PU]};

    always_comb begin
        set_vec.pi = pb_tc || (single_dma && cap_tc);
        set_vec.ci = cap_tc && !single_dma;
        set_vec.ti = tmr_tc;
        clr_vec.pi = clr_all || (alt_wr && !alt_wdata[BIT_PI]);
        clr_vec.ci = clr_all || (alt_wr && !alt_wdata[BIT_CI]);
        clr_vec.ti = clr_all || (alt_wr && !alt_wdata[BIT_TI]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.pi <= set_vec.pi || (flags.pi && !clr_vec.pi);
            flags.ci <= set_vec.ci || (flags.ci && !clr_vec.ci);
            flags.ti <= set_vec.ti || (flags.ti && !clr_vec.ti);
        end
    end

    // R7 / R11: a playback count pulse sets PI in both modes
    a_r7_pi_latch: assert property (@(posedge clk) disable iff (rst)
        pb_tc |=> flags.pi);

    // R11: in single-channel mode CI cannot rise
    a_r11_ci_quiet: assert property (@(posedge clk) disable iff (rst)
        (single_dma && !flags.ci) |=> !flags.ci);

    // R11: capture pulse in single-channel mode lands on PI
    a_r11_cap_to_pi: assert property (@(posedge clk) disable iff (rst)
        (single_dma && cap_tc) |=> flags.pi);

    // R8: writing 1 leaves a pending timer flag alone
    a_r8_one_keeps: assert property (@(posedge clk) disable iff (rst)
        (flags.ti && alt_wr && alt_wdata[BIT_TI] && !clr_all) |=> flags.ti);

    // R10: timer pulse wins over any clear
    a_r10_ti_set_wins: assert property (@(posedge clk) disable iff (rst)
        tmr_tc |=> flags.ti);

endmodule

// File: rtl/audio_fifo_status.sv
module audio_fifo_status
    import afs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pb_wr,
    input  logic [DATA_W-1:0] pb_wr_data,
    input  logic              pb_req,
    output logic [DATA_W-1:0] pb_sample,
    output logic              pb_sample_vld,
    input  logic              cap_strobe,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              cap_rd,
    output logic [DATA_W-1:0] cap_rd_data,
    output logic              cap_rd_vld,
    input  logic              cnt_pb_tc,
    input  logic              cnt_cap_tc,
    input  logic              tmr_tc,
    input  logic              single_dma,
    input  logic              alt_wr,
    input  logic [STAT_W-1:0] alt_wdata,
    input  logic              main_wr,
    output logic [STAT_W-1:0] status_q,
    output logic              irq
);

    logic       pb_full, pb_empty, pb_drop, pb_miss;
    logic       cap_full, cap_empty, cap_drop, cap_miss;
    err_flags_t err_evt;
    err_flags_t err_q;
    irq_flags_t irq_q;

    afs_byte_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (DATA_W)
    ) u_pb_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (pb_wr),
        .push_data (pb_wr_data),
        .pop       (pb_req),
        .rd_data   (pb_sample),
        .rd_vld    (pb_sample_vld),
        .full      (pb_full),
        .empty     (pb_empty),
        .push_drop (pb_drop),
        .pop_miss  (pb_miss)
    );

    afs_byte_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (DATA_W)
    ) u_cap_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (cap_strobe),
        .push_data (cap_data),
        .pop       (cap_rd),
        .rd_data   (cap_rd_data),
        .rd_vld    (cap_rd_vld),
        .full      (cap_full),
        .empty     (cap_empty),
        .push_drop (cap_drop),
        .pop_miss  (cap_miss)
    );

    logic unused_levels;
    assign unused_levels = ^{pb_full, pb_empty, cap_full, cap_empty};

    always_comb begin
        err_evt.pu = pb_miss;
        err_evt.po = pb_drop;
        err_evt.co = cap_drop;
        err_evt.cu = cap_miss;
    end

    afs_err_latch #(
        .N (N_ERR)
    ) u_err (
        .clk     (clk),
        .rst     (rst),
        .evt     (err_evt),
        .clr_all (main_wr),
        .flags   (err_q)
    );

    afs_irq_latch u_irq (
        .clk        (clk),
        .rst        (rst),
        .pb_tc      (cnt_pb_tc),
        .cap_tc     (cnt_cap_tc),
        .tmr_tc     (tmr_tc),
        .single_dma (single_dma),
        .alt_wr     (alt_wr),
        .alt_wdata  (alt_wdata),
        .clr_all    (main_wr),
        .flags      (irq_q)
    );

    assign status_q = pack_status(irq_q, err_q);
    assign irq      = irq_q.pi || irq_q.ci || irq_q.ti;

    // R9: a main-status write with no set event empties the status byte
    a_r9_main_clear: assert property (@(posedge clk) disable iff (rst)
        (main_wr && !cnt_pb_tc && !cnt_cap_tc && !tmr_tc
         && !pb_wr && !pb_req && !cap_strobe && !cap_rd) |=> (status_q == '0 && !irq));

    // R8: an alternate write never touches the error half
    a_r8_err_untouched: assert property (@(posedge clk) disable iff (rst)
        (alt_wr && !main_wr && !pb_wr && !pb_req && !cap_strobe && !cap_rd)
        |=> $stable(status_q[BIT_CU:BIT_PU]));

    // R3: playback underrun never produces a sample pulse
    a_r3_no_sample: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[BIT_PU]) |-> !pb_sample_vld);

endmodule

// File: tb/test_audio_fifo_status.sv
module test_audio_fifo_status;

    logic       clk = 1'b0;
    logic       rst;
    logic       pb_wr = 0, pb_req = 0, cap_strobe = 0, cap_rd = 0;
    logic [7:0] pb_wr_data = 0, cap_data = 0, alt_wdata = 0;
    logic       cnt_pb_tc = 0, cnt_cap_tc = 0, tmr_tc = 0, single_dma = 0;
    logic       alt_wr = 0, main_wr = 0;
    logic [7:0] pb_sample, cap_rd_data, status_q;
    logic       pb_sample_vld, cap_rd_vld, irq;

    int         n_checks = 0;
    int         n_fails  = 0;
    logic [7:0] pb_q [$];
    logic [7:0] cap_q [$];
    logic [7:0] exp_b;

    always #10 clk = ~clk;

    audio_fifo_status i_audio_fifo_status (
        .clk (clk), .rst (rst),
        .pb_wr (pb_wr), .pb_wr_data (pb_wr_data), .pb_req (pb_req),
        .pb_sample (pb_sample), .pb_sample_vld (pb_sample_vld),
        .cap_strobe (cap_strobe), .cap_data (cap_data), .cap_rd (cap_rd),
        .cap_rd_data (cap_rd_data), .cap_rd_vld (cap_rd_vld),
        .cnt_pb_tc (cnt_pb_tc), .cnt_cap_tc (cnt_cap_tc), .tmr_tc (tmr_tc),
        .single_dma (single_dma), .alt_wr (alt_wr), .alt_wdata (alt_wdata),
        .main_wr (main_wr), .status_q (status_q), .irq (irq)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares every delivered byte with the queue head
    always @(negedge clk) begin
        if (rst === 1'b0) begin
            if (pb_sample_vld) begin
                if (pb_q.size() == 0) check8("R3 unexpected playback pulse", pb_sample, 8'hxx);
                else begin exp_b = pb_q.pop_front(); check8("R2 playback order", pb_sample, exp_b); end
            end
            if (cap_rd_vld) begin
                if (cap_q.size() == 0) check8("R6 unexpected capture pulse", cap_rd_data, 8'hxx);
                else begin exp_b = cap_q.pop_front(); check8("R2 capture order", cap_rd_data, exp_b); end
            end
        end
    end

    task automatic pb_push(input logic [7:0] d, input bit keep);
        @(negedge clk); pb_wr = 1; pb_wr_data = d;
        if (keep) pb_q.push_back(d);
        @(negedge clk); pb_wr = 0;
    endtask

    task automatic pb_pop();
        @(negedge clk); pb_req = 1;
        @(negedge clk); pb_req = 0;
    endtask

    task automatic cap_push(input logic [7:0] d, input bit keep);
        @(negedge clk); cap_strobe = 1; cap_data = d;
        if (keep) cap_q.push_back(d);
        @(negedge clk); cap_strobe = 0;
    endtask

    task automatic cap_pop();
        @(negedge clk); cap_rd = 1;
        @(negedge clk); cap_rd = 0;
    endtask

    task automatic alt_write(input logic [7:0] d);
        @(negedge clk); alt_wr = 1; alt_wdata = d;
        @(negedge clk); alt_wr = 0;
    endtask

    task automatic main_write();
        @(negedge clk); main_wr = 1;
        @(negedge clk); main_wr = 0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check8("R1 status after reset", status_q, 8'h00);
        check8("R1 irq after reset", {7'd0, irq}, 8'h00);

        // R2: short in-order stream
        pb_push(8'hA1, 1); pb_push(8'hB2, 1); pb_push(8'hC3, 1);
        pb_pop(); pb_pop(); pb_pop();
        check8("R2 no error flags", status_q, 8'h00);

        // R3: request on empty
        pb_pop();
        check8("R3 underrun flag", status_q, 8'h01);
        check8("R3 sample held", pb_sample, 8'hC3);

        main_write();
        check8("R9 main clear", status_q, 8'h00);

        // R4: overfill playback
        for (int i = 0; i < 17; i++) pb_push(8'h10 + 8'(i), i < 16);
        check8("R4 overrun flag", status_q, 8'h02);
        for (int i = 0; i < 16; i++) pb_pop();
        check8("R4 drained no underrun", status_q, 8'h02);
        pb_pop();
        check8("R4 dropped byte absent", status_q, 8'h03);

        alt_write(8'h00);
        check8("R8 error bits untouched", status_q, 8'h03);
        main_write();

        // R5 / R6: capture path
        for (int i = 0; i < 17; i++) cap_push(8'h40 + 8'(i), i < 16);
        check8("R5 capture overrun", status_q, 8'h04);
        for (int i = 0; i < 16; i++) cap_pop();
        check8("R5 no capture underrun yet", status_q, 8'h04);
        cap_pop();
        check8("R6 capture underrun", status_q, 8'h0C);
        check8("R6 last byte repeated", cap_rd_data, 8'h4F);
        cap_push(8'h77, 1); cap_pop();
        check8("R6 pointers intact", status_q, 8'h0C);
        main_write();

        // R7: interrupt latching
        @(negedge clk); cnt_pb_tc = 1; @(negedge clk); cnt_pb_tc = 0;
        check8("R7 PI", status_q, 8'h10);
        check8("R7 irq", {7'd0, irq}, 8'h01);
        @(negedge clk); cnt_cap_tc = 1; @(negedge clk); cnt_cap_tc = 0;
        check8("R7 CI", status_q, 8'h30);
        @(negedge clk); tmr_tc = 1; @(negedge clk); tmr_tc = 0;
        check8("R7 TI", status_q, 8'h70);

        // R8 / R12
        alt_write(8'hFF);
        check8("R8 ones keep, R12 bit7 zero", status_q, 8'h70);
        alt_write(8'hDF);
        check8("R8 clear CI only", status_q, 8'h50);
        alt_write(8'h00);
        check8("R8 clear all irq", status_q, 8'h00);
        check8("R7 irq low", {7'd0, irq}, 8'h00);

        // R10: set beats clear
        @(negedge clk); cnt_pb_tc = 1; alt_wr = 1; alt_wdata = 8'h00;
        @(negedge clk); cnt_pb_tc = 0; alt_wr = 0;
        check8("R10 PI set wins alt", status_q, 8'h10);
        @(negedge clk); tmr_tc = 1; main_wr = 1;
        @(negedge clk); tmr_tc = 0; main_wr = 0;
        check8("R10 TI set wins main", status_q, 8'h40);
        main_write();

        // R11: single channel routing
        single_dma = 1;
        @(negedge clk); cnt_cap_tc = 1; @(negedge clk); cnt_cap_tc = 0;
        check8("R11 capture count to PI", status_q, 8'h10);
        single_dma = 0;
        main_write();
        check8("R9 final clear", status_q, 8'h00);

        check8("R2 playback queue drained", 8'(pb_q.size()), 8'h00);
        check8("R2 capture queue drained", 8'(cap_q.size()), 8'h00);
        finish_run();
    end

endmodule